// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block takes parallel samples from a valid/ready source and sends them out one bit at a time on a serial data line. The line comes with a bit clock and a frame sync. The bit clock runs at the system clock divided by a programmable ratio. Each frame is a programmable number of bit slots long. The first slot of a frame carries the sync pulse. The sample word follows it, MSB first, with a programmable length. Any slots left in the frame after the word are idle.

Three configuration fields are loaded through a small write port. Each field holds its value minus one. Writing any of them restarts the frame from its first slot, so the new settings take effect on a clean frame boundary.

The sample source is polled once per frame, on the last clock of the frame. If no sample is offered then, the next frame carries an all-zero word. If the frame is shorter than the word, the word is cut off when the next sync arrives.

Top module: `serial_sample_tx`

## Requirements
- R1: After reset, the three configuration fields hold their default values:
  - address 0, bits [3:0]: divider = 1;
  - address 1, bits [4:0]: word length minus one = 17;
  - address 2, bits [6:0]: frame length minus one = 25.
- R2: A bit slot lasts divider+1 system clocks. Within a slot, `sclk_o` is low for the first floor((divider+1)/2) clocks and high for the remaining clocks.
- R3: A frame lasts (frame field + 1) slots. `fsync_o` is high for exactly the whole of slot 0 of each frame.
- R4: Slots 1 to (length field + 1) carry the sample MSB first. Slot 1 carries sample bit [length field].
- R5: `sdata_o` is low in the sync slot and in every slot after the last word bit.
- R6: `s_ready_o` is high only during the last clock of the last slot of a frame. A sample accepted in that clock is sent in the frame that follows.
- R7: If `s_valid_i` is low when `s_ready_o` is high, the next frame carries an all-zero word.
- R8: If the frame has fewer slots than the word plus the sync slot, the word is truncated. The next frame's sync cuts it off, and the remaining bits are dropped.
- R9: A write to address 0, 1 or 2 restarts the block. In the clock after the write edge, the block is at slot 0, clock 0, and any word already loaded is discarded. As a result, the first frame after a write carries zeros.
- R10: A write to address 3 changes nothing: no field changes, and the frame timing is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration field select |
| cfg_wdata_i | input | 8 | Configuration write data |
| s_valid_i | input | 1 | Sample valid |
| s_data_i | input | 32 | Sample word, right aligned |
| s_ready_o | output | 1 | Sample taken at the frame boundary |
| sclk_o | output | 1 | Serial bit clock |
| sdata_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame sync, one slot wide |

## Verification
The three counters each show up in a different place at the ports:
- A wrong divider count bends the `sclk_o` duty pattern within a single slot.
- A wrong slot count moves `fsync_o` and `s_ready_o` within one frame.
- A wrong shift register makes `sdata_o` disagree with the sample bit order in the first loaded frame after a restart.

The bench compares every output on every clock against values computed from the field settings. It does this for several divider, length and frame combinations, including truncation and a one-bit word. A shift or load error is therefore caught no later than the second frame after a write.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned DIV_W  = 4;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned FRM_W  = 7;
  localparam int unsigned CFG_DW = 8;
  localparam int unsigned CFG_AW = 2;

  localparam logic [CFG_AW-1:0] ADDR_DIV = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_LEN = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_FRM = 2'd2;

  localparam logic [DIV_W-1:0] DIV_RST = 4'd1;
  localparam logic [LEN_W-1:0] LEN_RST = 5'd17;
  localparam logic [FRM_W-1:0] FRM_RST = 7'd25;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len;
    logic [FRM_W-1:0] frm;
  } sst_cfg_t;
endpackage

// File: rtl/sst_cfg_regs.sv
module sst_cfg_regs
  import sst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output sst_cfg_t          cfg_o,
  output logic              restart_o
);
  sst_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.div <= DIV_RST;
      cfg_q.len <= LEN_RST;
      cfg_q.frm <= FRM_RST;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_DIV: cfg_q.div <= wdata_i[DIV_W-1:0];
        ADDR_LEN: cfg_q.len <= wdata_i[LEN_W-1:0];
        ADDR_FRM: cfg_q.frm <= wdata_i[FRM_W-1:0];
        default:  ;
      endcase
    end
  end

  assign cfg_o     = cfg_q;
  assign restart_o = we_i && (addr_i == ADDR_DIV || addr_i == ADDR_LEN || addr_i == ADDR_FRM);

  AST_UNMAPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd3) |=> $stable(cfg_q)) else $error("unmapped write changed cfg"); // R10
endmodule

// File: rtl/sst_bitclk.sv
module sst_bitclk
  import sst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             sclk_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [CW-1:0]    half;

  assign half   = ({1'b0, div_i} + CW'(1)) >> 1;
  assign tick_o = (cnt_q >= div_i);
  assign sclk_o = ({1'b0, cnt_q} >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_i) else $error("divider count overran"); // R2
  AST_TICK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |-> sclk_o) else $error("sclk low at slot end"); // R2
endmodule

// File: rtl/sst_framer.sv
module sst_framer
  import sst_pkg::*;
#(
  parameter int unsigned SMP_W = 1 << LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [FRM_W-1:0] frm_i,
  input  logic             s_valid_i,
  input  logic [SMP_W-1:0] s_data_i,
  output logic             s_ready_o,
  output logic             sdata_o,
  output logic             fsync_o
);
  localparam int unsigned EW = (FRM_W > LEN_W ? FRM_W : LEN_W) + 1;

  logic [FRM_W-1:0] slot_q;
  logic [SMP_W-1:0] shreg_q;
  logic             last_slot;
  logic             in_word;
  logic [EW-1:0]    word_end;

  assign last_slot = (slot_q >= frm_i);
  assign word_end  = EW'(len_i) + EW'(1);
  assign in_word   = (slot_q != '0) && (EW'(slot_q) <= word_end);
  assign s_ready_o = tick_i && last_slot && !restart_i;
  assign fsync_o   = (slot_q == '0);
  assign sdata_o   = in_word && shreg_q[len_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      shreg_q <= '0;
    end else if (restart_i) begin
      slot_q  <= '0;
      shreg_q <= '0;
    end else if (tick_i) begin
      if (last_slot) begin
        slot_q  <= '0;
        shreg_q <= s_valid_i ? s_data_i : '0;  // idle frame sends zeros
      end else begin
        slot_q <= slot_q + 1'b1;
        if (slot_q != '0) shreg_q <= shreg_q << 1;
      end
    end
  end

  AST_READY_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |=> fsync_o) else $error("ready not at frame end"); // R6
  AST_RESTART_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (fsync_o && !sdata_o && shreg_q == '0)) else $error("restart not clean"); // R9
  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= frm_i) else $error("slot beyond frame"); // R3
  AST_FSYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> !sdata_o) else $error("data during sync slot"); // R5
endmodule

// File: rtl/serial_sample_tx.sv
module serial_sample_tx
  import sst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              s_valid_i,
  input  logic [31:0]       s_data_i,
  output logic              s_ready_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              fsync_o
);
  localparam int unsigned SMP_W = 1 << LEN_W;

  sst_cfg_t cfg;
  logic     restart;
  logic     tick;

  sst_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  sst_bitclk u_bitclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .div_i     (cfg.div),
    .tick_o    (tick),
    .sclk_o    (sclk_o)
  );

  sst_framer #(.SMP_W(SMP_W)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick),
    .len_i     (cfg.len),
    .frm_i     (cfg.frm),
    .s_valid_i (s_valid_i),
    .s_data_i  (s_data_i),
    .s_ready_o (s_ready_o),
    .sdata_o   (sdata_o),
    .fsync_o   (fsync_o)
  );

  AST_WRITE_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (fsync_o && !s_ready_o)) else $error("write did not resync"); // R9
endmodule

// File: tb/serial_sample_tx_tb_top.sv
module serial_sample_tx_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;

  localparam int          V_DIV [NV] = '{0, 3, 2, 15, 1, 4};
  localparam int          V_LEN [NV] = '{7, 17, 31, 3, 11, 0};
  localparam int          V_FRM [NV] = '{9, 25, 33, 5, 6, 1};
  localparam logic [31:0] V_DAT [NV] = '{32'hA5, 32'h2B3C5, 32'hDEADBEEF, 32'h9, 32'hF0F, 32'h1};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        s_valid_i = 1'b0;
  logic [31:0] s_data_i = '0;
  logic        s_ready_o, sclk_o, sdata_o, fsync_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_sample_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
    .s_ready_o(s_ready_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .fsync_o(fsync_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(int addr, int val);
    cfg_we_i    = 1'b1;
    cfg_addr_i  = 2'(addr);
    cfg_wdata_i = 8'(val);
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  // Program all fields; the last write restarts the frame, leaving the bench at t=0.
  task automatic program_cfg(int div, int len, int frm, logic [31:0] d, logic v);
    s_data_i  = d;
    s_valid_i = v;
    cfg_write(0, div);
    cfg_write(1, len);
    cfg_write(2, frm);
  endtask

  // Compare every output each clock against the requirement-derived timing.
  // Mismatch counts per output become one check each.
  task automatic run_vec(int div, int len, int frm, logic [31:0] d, logic v,
                         int ncyc, int bad_at, string dtag);
    int e_fs = 0, e_ck = 0, e_rd = 0, e_dt = 0, e_idle = 0, e_f0 = 0;
    int last_dt_a = 0, last_dt_e = 0;
    int sl = div + 1;
    int p  = frm + 1;
    for (int t = 0; t < ncyc; t++) begin
      int c = t % sl;
      int s = (t / sl) % p;
      int f = t / (sl * p);
      int xfs = (s == 0) ? 1 : 0;
      int xck = (c >= sl / 2) ? 1 : 0;
      int xrd = (c == div && s == p - 1) ? 1 : 0;
      int inw = (s >= 1 && s <= len + 1) ? 1 : 0;
      int xdt = (v && f >= 1 && inw == 1) ? int'(d[len - (s - 1)]) : 0;
      if (cfg_we_i) cfg_we_i = 1'b0;
      if (int'(fsync_o) != xfs) e_fs++;
      if (int'(sclk_o) != xck) e_ck++;
      if (int'(s_ready_o) != xrd) e_rd++;
      if (int'(sdata_o) != xdt) begin
        e_dt++; last_dt_a = int'(sdata_o); last_dt_e = xdt;
      end
      if (inw == 0 && sdata_o) e_idle++;
      if (f == 0 && sdata_o) e_f0++;
      if (t == bad_at) begin
        cfg_we_i = 1'b1; cfg_addr_i = 2'd3; cfg_wdata_i = 8'hFF;
      end
      @(negedge clk_i);
    end
    cfg_we_i = 1'b0;
    check("R3 fsync mismatches", e_fs, 0);
    check("R2 sclk mismatches", e_ck, 0);
    check("R6 ready mismatches", e_rd, 0);
    check(dtag, e_dt, 0);
    if (e_dt != 0) $display("  last data bit actual=%0d expected=%0d", last_dt_a, last_dt_e);
    check("R5 data in idle or sync slot", e_idle, 0);
    check("R9 data in first frame after restart", e_f0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    s_valid_i = 1'b1;
    s_data_i  = 32'h2A5C3;
    repeat (3) @(negedge clk_i);
    // Reset state: slot 0, clock 0 with divider 1
    check("R3 fsync in reset", int'(fsync_o), 1);
    check("R5 sdata in reset", int'(sdata_o), 0);
    check("R2 sclk in reset", int'(sclk_o), 0);
    check("R6 ready in reset", int'(s_ready_o), 0);
    rst_ni = 1'b1;
    // R1: default fields drive the stream without any write
    run_vec(1, 17, 25, 32'h2A5C3, 1'b1, 2 * 26 * 3, -1, "R1 default-field data mismatches");

    // Vector table; index 4 has frame shorter than word (R8)
    for (int i = 0; i < NV; i++) begin
      int n = (V_DIV[i] + 1) * (V_FRM[i] + 1) * 3;
      program_cfg(V_DIV[i], V_LEN[i], V_FRM[i], V_DAT[i], 1'b1);
      run_vec(V_DIV[i], V_LEN[i], V_FRM[i], V_DAT[i], 1'b1, n, -1,
              (i == 4) ? "R8 truncated data mismatches" : "R4 data mismatches");
    end

    // R7: no valid sample at frame boundary gives zero words
    program_cfg(2, 9, 14, 32'h3FF, 1'b0);
    run_vec(2, 9, 14, 32'h3FF, 1'b0, 3 * 15 * 3, -1, "R7 zero-word mismatches");

    // R10: unmapped write in the middle of a frame leaves timing and fields alone
    program_cfg(1, 7, 11, 32'hC3, 1'b1);
    run_vec(1, 7, 11, 32'hC3, 1'b1, 2 * 12 * 4, 2 * 12 + 7, "R10 data after unmapped write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule